// File: doc/BRIEF.md
# Prescaled Interval Timer Trio

This block holds three independent interval timers for an audio coprocessor. Every timer has a free-running prescaler that turns the base clock into a slower tick. The default prescale is 128 base clocks for the two slow timers and 16 for the fast one. Each timer counts its ticks in an 8-bit divider and compares the divider with a programmable 8-bit period. Each time the divider completes one period, the timer advances a small 4-bit event counter that software polls.

Software gives each timer a period through its own write strobe and a shared data byte. Each timer has its own enable bit. Software drains a counter with a read strobe. The read returns the count on the read-data port in the same cycle and leaves the counter at zero. A separate clear strobe zeroes a counter without returning its value. A polling loop therefore sees how many periods have elapsed since its last read, up to fifteen.

Top module: `tick_timer_trio`

## Requirements
- R1: The period is 8 bits wide, and a period value of 0 means 256 prescaled ticks between counter increments.
- R2: While a timer is enabled, each prescaled tick advances its divider by one. The tick on which the divider would reach the period returns the divider to 0 and adds one to the counter, so a timer with period P increments once every P prescaled ticks.
- R3: The counter is 4 bits wide and wraps from 15 to 0 on an increment.
- R4: While read strobe `cnt_rd[i]` is high, `rd_data` shows counter i in the same cycle, and counter i is 0 after that clock edge. When several read bits are high, the lowest index is returned. When no read bit is high, `rd_data` is 0.
- R5: While a timer's enable is low, its divider and counter hold their values. Only a read or a clear strobe can change the counter then.
- R6: On the clock where a timer's enable goes from 0 to 1, both its divider and its counter are set to 0, whatever else is requested in that cycle.
- R7: Bit i of `tmr_en`, `per_wr`, `cnt_rd` and `cnt_clr` belongs to timer i (i = 0, 1, 2). Counter i is driven on `cnt_val[4*i+3:4*i]`.
- R8: A pulse on `cnt_clr[i]` sets counter i to 0 after that clock edge.
- R9: A period write whose data equals the current period leaves the divider, the counter and the period unchanged.
- R10: Each prescaler runs freely from reset, whatever the enables are. The prescale is 128 base clocks for timers 0 and 1 and 16 for timer 2, and both values are parameters.
- R11: If a read or clear falls in the same cycle as an increment, the increment is kept and the counter becomes 1.
- R12: If the period is lowered below the current divider value, the divider keeps counting up, wraps through 255 to 0, and fires when it next reaches the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 3 | Per-timer enable, bit i for timer i |
| per_wr | input | 3 | Per-timer period write strobe |
| per_data | input | 8 | Period value, shared by all write strobes |
| cnt_rd | input | 3 | Per-timer destructive read strobe |
| cnt_clr | input | 3 | Per-timer counter clear strobe |
| rd_data | output | 4 | Counter value of the lowest-index timer being read |
| cnt_val | output | 12 | Current counters, 4 bits per timer |

## Verification
The period function is tried with the smallest period (1), small odd and even periods, and the encoded maximum (0). This separates an off-by-one in the divider compare, and a zero period wrongly treated as zero, from the intended 256-tick interval. Enable toggling, same-value and lowered period writes, and reads or clears placed exactly on an increment cycle each isolate one priority rule. The bench finds the collision cycle from its own reference model. Running the slow and fast timers together with different periods shows whether each enable bit and each prescaler belongs to the right lane.

// File: rtl/tt_pkg.sv
package tt_pkg;
  parameter int unsigned TT_PER_W = 8;
  parameter int unsigned TT_CNT_W = 4;

  // divider value one tick later, modulo 2^TT_PER_W
  function automatic logic [TT_PER_W-1:0] tt_div_inc(input logic [TT_PER_W-1:0] d);
    return d + 1'b1;
  endfunction

  // true when the next tick completes one period (period 0 stands for 2^TT_PER_W)
  function automatic logic tt_hit(input logic [TT_PER_W-1:0] d,
                                  input logic [TT_PER_W-1:0] p);
    return tt_div_inc(d) == p;
  endfunction

  // counter update: increment wins over a clear, clear alone gives zero
  function automatic logic [TT_CNT_W-1:0] tt_cnt_next(input logic [TT_CNT_W-1:0] c,
                                                      input logic inc,
                                                      input logic clr);
    logic [TT_CNT_W-1:0] r;
    if (inc) r = clr ? TT_CNT_W'(1) : c + 1'b1;
    else if (clr) r = '0;
    else r = c;
    return r;
  endfunction
endpackage

// File: rtl/tt_prescale.sv
module tt_prescale #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  assign tick_o = (pcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  // R10
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o || (DIV == 1));
endmodule

// File: rtl/tt_lane.sv
module tt_lane
  import tt_pkg::*;
#(
  parameter int unsigned PRE = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                per_we_i,
  input  logic [TT_PER_W-1:0] per_d_i,
  input  logic                clear_i,
  output logic [TT_CNT_W-1:0] cnt_o
);
  logic                tick;
  logic                en_q;
  logic                en_rise;
  logic                inc;
  logic [TT_PER_W-1:0] per_q;
  logic [TT_PER_W-1:0] div_q;
  logic [TT_CNT_W-1:0] cnt_q;

  tt_prescale #(.DIV(PRE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  assign en_rise = en_i & ~en_q;
  assign inc     = en_i & ~en_rise & tick & tt_hit(div_q, per_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else en_q <= en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else if (per_we_i && (per_d_i != per_q)) per_q <= per_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (en_rise) div_q <= '0;
    else if (en_i && tick) div_q <= inc ? '0 : tt_div_inc(div_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en_rise) cnt_q <= '0;
    else cnt_q <= tt_cnt_next(cnt_q, inc, clear_i);
  end

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear_i && (cnt_q == {TT_CNT_W{1'b1}})) |=> (cnt_q == '0));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !inc) |=> (cnt_q == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clear_i) |=> ($stable(cnt_q) && $stable(div_q)));
  // R6
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> ((cnt_q == '0) && (div_q == '0)));
  // R11
  clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && clear_i) |=> (cnt_q == TT_CNT_W'(1)));
  // R2
  period_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (div_q == '0));
endmodule

// File: rtl/tick_timer_trio.sv
module tick_timer_trio
  import tt_pkg::*;
#(
  parameter int unsigned PRE_SLOW = 128,
  parameter int unsigned PRE_FAST = 16,
  parameter int unsigned N_TMR    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TMR-1:0]          tmr_en,
  input  logic [N_TMR-1:0]          per_wr,
  input  logic [TT_PER_W-1:0]       per_data,
  input  logic [N_TMR-1:0]          cnt_rd,
  input  logic [N_TMR-1:0]          cnt_clr,
  output logic [TT_CNT_W-1:0]       rd_data,
  output logic [N_TMR*TT_CNT_W-1:0] cnt_val
);
  logic [TT_CNT_W-1:0] lane_cnt [N_TMR];

  for (genvar g = 0; g < N_TMR; g++) begin : g_lane
    localparam int unsigned LPRE = (g == N_TMR - 1) ? PRE_FAST : PRE_SLOW;
    tt_lane #(.PRE(LPRE)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (tmr_en[g]),
      .per_we_i(per_wr[g]),
      .per_d_i (per_data),
      .clear_i (cnt_rd[g] | cnt_clr[g]),
      .cnt_o   (lane_cnt[g])
    );
    assign cnt_val[g*TT_CNT_W +: TT_CNT_W] = lane_cnt[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = N_TMR - 1; i >= 0; i--) begin
      if (cnt_rd[i]) rd_data = lane_cnt[i];
    end
  end

  // R4
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd == '0) |-> (rd_data == '0));
endmodule

// File: tb/tb_tick_timer_trio.sv
module tb_tick_timer_trio;
  localparam int PS = 128;
  localparam int PF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tmr_en = '0;
  logic [2:0] per_wr = '0;
  logic [7:0] per_data = '0;
  logic [2:0] cnt_rd = '0;
  logic [2:0] cnt_clr = '0;
  logic [3:0] rd_data;
  logic [11:0] cnt_val;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R10";

  int m_pc [3];
  int m_div [3];
  int m_cnt [3];
  int m_per [3];
  bit m_ep [3];

  tick_timer_trio #(.PRE_SLOW(PS), .PRE_FAST(PF), .N_TMR(3)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .per_wr(per_wr),
    .per_data(per_data), .cnt_rd(cnt_rd), .cnt_clr(cnt_clr),
    .rd_data(rd_data), .cnt_val(cnt_val)
  );

  always #5 clk = ~clk;

  function automatic int pre_of(int i);
    return (i == 2) ? PF : PS;
  endfunction

  function automatic int per_ticks(int p);
    return (p == 0) ? 256 : p;
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_pc[i] = 0; m_div[i] = 0; m_cnt[i] = 0; m_per[i] = 0; m_ep[i] = 0;
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) begin
        m_pc[i] = 0; m_div[i] = 0; m_cnt[i] = 0; m_per[i] = 0; m_ep[i] = 0;
      end else begin
        bit tk, rise, hit, clr;
        tk = (m_pc[i] == pre_of(i) - 1);
        m_pc[i] = tk ? 0 : m_pc[i] + 1;
        rise = tmr_en[i] && !m_ep[i];
        clr = cnt_rd[i] || cnt_clr[i];
        hit = 0;
        if (rise) begin
          m_div[i] = 0; m_cnt[i] = 0;
        end else begin
          if (tmr_en[i] && tk) begin
            m_div[i] = m_div[i] + 1;
            if (m_div[i] == per_ticks(m_per[i])) begin
              m_div[i] = 0; hit = 1;
            end else if (m_div[i] == 256) m_div[i] = 0;
          end
          if (hit) m_cnt[i] = clr ? 1 : (m_cnt[i] + 1) % 16;
          else if (clr) m_cnt[i] = 0;
        end
        m_ep[i] = tmr_en[i];
        if (per_wr[i]) m_per[i] = per_data;
      end
    end
  end

  function automatic int model_rd();
    for (int i = 0; i < 3; i++) if (cnt_rd[i]) return m_cnt[i];
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < 3; i++)
        check({cur_req, " cnt"}, int'(cnt_val[4*i +: 4]), m_cnt[i]);
      check({cur_req, " rd_data"}, int'(rd_data), model_rd());
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_per(int i, int v);
    @(negedge clk);
    per_wr = 3'b001 << i; per_data = 8'(v);
    @(negedge clk);
    per_wr = '0;
  endtask

  task automatic pulse_rd(int i);
    @(negedge clk);
    cnt_rd = 3'b001 << i;
    @(negedge clk);
    cnt_rd = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cyc(3);
    check("R10 reset cnt_val", int'(cnt_val), 0);
    check("R4 reset rd_data", int'(rd_data), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R10: fast timer period 3, slow timer 0 period 2
    cur_req = "R2";
    wr_per(2, 3);
    wr_per(0, 2);
    @(negedge clk); tmr_en = 3'b101;
    cyc(PF * 3 * 5 + 20);
    check("R2 fast count", int'(cnt_val[11:8]), m_cnt[2]);
    cur_req = "R10";
    cyc(PS * 2 * 3);
    check("R10 slow count", int'(cnt_val[3:0]), m_cnt[0]);

    // R7: timer 1 alone with a different period
    cur_req = "R7";
    wr_per(1, 1);
    @(negedge clk); tmr_en = 3'b111;
    cyc(PS * 3 + 5);

    // R4: destructive read
    cur_req = "R4";
    pulse_rd(2);
    check("R4 cleared after read", int'(cnt_val[11:8]), m_cnt[2]);
    @(negedge clk); cnt_rd = 3'b110;
    #2 check("R4 lowest index wins", int'(rd_data), m_cnt[1]);
    @(negedge clk); cnt_rd = '0;

    // R3: wrap with period 1
    cur_req = "R3";
    wr_per(2, 1);
    cyc(PF * 20);

    // R8: clear strobe
    cur_req = "R8";
    @(negedge clk); cnt_clr = 3'b100;
    @(negedge clk); cnt_clr = '0;
    #2 check("R8 cleared", int'(cnt_val[11:8]), m_cnt[2]);
    cyc(PF * 4);

    // R5: disabled timer holds
    cur_req = "R5";
    @(negedge clk); tmr_en = 3'b011;
    begin
      int held;
      held = int'(cnt_val[11:8]);
      cyc(PF * 10);
      check("R5 held while disabled", int'(cnt_val[11:8]), held);
    end

    // R6: re-enable clears
    cur_req = "R6";
    @(negedge clk); tmr_en = 3'b111;
    @(negedge clk);
    #2 check("R6 cleared on enable", int'(cnt_val[11:8]), 0);
    cyc(PF * 3);

    // R11: read on an increment cycle
    cur_req = "R11";
    while (!(m_pc[2] == PF - 1 && m_ep[2] && ((m_div[2] + 1) % 256) == m_per[2] % 256))
      @(negedge clk);
    cnt_rd = 3'b100;
    @(negedge clk); cnt_rd = '0;
    #2 check("R11 increment kept", int'(cnt_val[11:8]), 1);
    cyc(PF * 2);

    // R9: same-value period write mid-count
    cur_req = "R9";
    wr_per(2, 5);
    cyc(PF * 7);
    wr_per(2, 5);
    cyc(PF * 12);

    // R12: lower the period below the divider
    cur_req = "R12";
    wr_per(2, 200);
    @(negedge clk); tmr_en = 3'b011;
    @(negedge clk); tmr_en = 3'b111;
    cyc(PF * 60);
    wr_per(2, 10);
    cyc(PF * 220);

    // R1: period 0 means 256 ticks
    cur_req = "R1";
    wr_per(2, 0);
    @(negedge clk); tmr_en = 3'b011;
    @(negedge clk); tmr_en = 3'b111;
    cyc(PF * 255);
    check("R1 no increment before 256 ticks", int'(cnt_val[11:8]), 0);
    cyc(PF * 2 + 4);
    check("R1 increment at 256 ticks", int'(cnt_val[11:8]), 1);

    cyc(10);
    finish_run();
  end
endmodule